// File: doc/BRIEF.md
# Load/Store Conflict Matrix

This block keeps memory operations in a safe order across a set of load/store units. It does not compare full addresses. When an operation is issued, the unit records whether it is a load or a store and keeps only the upper bits of its address as a compare key. A cache-line index can also serve as that key. The new operation is then blocked behind every older pending operation that might touch the same region, but only where at least one of the two is a store. Two loads never wait on each other.

Each unit gets two pairs of outputs. The first pair grants permission to read memory or to write memory. The second pair reports a read hold or a write hold, and the function unit dependency matrix uses these holds to stall the unit. When a unit signals completion, its column of blocking bits is cleared in every other unit and the unit itself is freed. The checks are conservative: if two keys are equal, the bench treats that as a possible overlap. Setting the key width equal to the address width turns the check into exact address matching.

Top module: `ls_conflict_matrix`

## Requirements
- R1: While rst_ni is low, and from reset until the first issue, every bit of rd_ok_o, wr_ok_o, rd_hold_o and wr_hold_o is 0.
- R2: A load issued while an older store with the same key is pending asserts rd_hold_o for its unit, not rd_ok_o.
- R3: A store issued while an older load with the same key is pending asserts wr_hold_o for its unit, not wr_ok_o.
- R4: A load issued while an older load with the same key is pending is not blocked, so rd_ok_o is set for it.
- R5: A store issued while an older store with the same key is pending waits: wr_hold_o is set until the older store completes.
- R6: The key is the top TAG_W bits of issue_addr_i (addr[ADDR_W-1 -: TAG_W]). Operations whose keys differ never block each other. Operations whose keys match but whose lower bits differ still block.
- R7: When done_valid_i is set for a unit, the next cycle shows all four outputs of that unit at 0. Every unit that was waiting only on it gets its permission in that same next cycle, and this includes an operation issued in the same cycle as the completion.
- R8: An issue aimed at a unit that is still busy is ignored, and the unit keeps its earlier operation type and permission.
- R9: For each unit, at most one of rd_ok_o, wr_ok_o, rd_hold_o and wr_hold_o is set, and a busy unit shows exactly one of them.
- R10: A later issue never takes away a permission already granted. A granted permission stays until its unit completes.
- R11: With TAG_W equal to ADDR_W, addresses that differ in any bit do not block each other, and identical addresses still block.
- R12: The issue encoding is issue_store_i = 1 for a store and 0 for a load. Results appear one cycle after the issuing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | Issue strobe |
| issue_unit_i | input | $clog2(N_UNITS) | Unit receiving the operation |
| issue_store_i | input | 1 | 1 = store, 0 = load |
| issue_addr_i | input | ADDR_W | Operation address; only the top TAG_W bits are used |
| done_valid_i | input | 1 | Completion strobe |
| done_unit_i | input | $clog2(N_UNITS) | Unit that completed and is freed |
| rd_ok_o | output | N_UNITS | Memory-read permission per unit |
| wr_ok_o | output | N_UNITS | Memory-write permission per unit |
| rd_hold_o | output | N_UNITS | Read hold to the function unit dependency matrix |
| wr_hold_o | output | N_UNITS | Write hold to the function unit dependency matrix |

## Verification
The hardest case to reach from the ports is a completion and a dependent issue in the same clock edge. In that case the freed unit must not enter the new operation's blocking row. The bench drives done_valid_i and issue_valid_i together on one falling edge to reach this case, and then checks that the newcomer is granted at once. A second instance with full-width keys is fed the same stimulus. Pairs that differ only in their low address bits therefore show conservative blocking on one instance and exact matching on the other.

// File: rtl/ls_cm_pkg.sv
package ls_cm_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;
endpackage

// File: rtl/ls_cm_tag_cmp.sv
module ls_cm_tag_cmp #(
  parameter int N_UNITS = 4,
  parameter int TAG_W   = 8
) (
  input  logic [TAG_W-1:0]              new_tag_i,
  input  logic                          new_store_i,
  input  logic [N_UNITS-1:0][TAG_W-1:0] ent_tag_i,
  input  logic [N_UNITS-1:0]            ent_store_i,
  input  logic [N_UNITS-1:0]            ent_live_i,
  output logic [N_UNITS-1:0]            conflict_o
);
  for (genvar j = 0; j < N_UNITS; j++) begin : g_cmp
    // load/load pairs never conflict
    assign conflict_o[j] = ent_live_i[j] && (ent_tag_i[j] == new_tag_i)
                           && (new_store_i || ent_store_i[j]);
  end
endmodule

// File: rtl/ls_cm_row.sv
module ls_cm_row #(
  parameter int N_UNITS = 4,
  parameter int TAG_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               free_i,
  input  logic               new_store_i,
  input  logic [TAG_W-1:0]   new_tag_i,
  input  logic [N_UNITS-1:0] conflict_i,
  input  logic [N_UNITS-1:0] clr_i,
  output logic               busy_o,
  output logic               store_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [N_UNITS-1:0] blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      store_o <= 1'b0;
      tag_o   <= '0;
      blk_o   <= '0;
    end else if (free_i) begin
      busy_o <= 1'b0;
      blk_o  <= '0;
    end else if (load_i) begin
      busy_o  <= 1'b1;
      store_o <= new_store_i;
      tag_o   <= new_tag_i;
      blk_o   <= conflict_i;
    end else begin
      blk_o <= blk_o & ~clr_i;
    end
  end
endmodule

// File: rtl/ls_cm_perm.sv
module ls_cm_perm #(
  parameter int N_UNITS = 4
) (
  input  logic [N_UNITS-1:0]              busy_i,
  input  logic [N_UNITS-1:0]              store_i,
  input  logic [N_UNITS-1:0][N_UNITS-1:0] blk_i,
  output logic [N_UNITS-1:0]              rd_ok_o,
  output logic [N_UNITS-1:0]              wr_ok_o,
  output logic [N_UNITS-1:0]              rd_hold_o,
  output logic [N_UNITS-1:0]              wr_hold_o
);
  for (genvar i = 0; i < N_UNITS; i++) begin : g_perm
    logic blocked;
    assign blocked      = |blk_i[i];
    assign rd_ok_o[i]   = busy_i[i] && !store_i[i] && !blocked;
    assign wr_ok_o[i]   = busy_i[i] &&  store_i[i] && !blocked;
    assign rd_hold_o[i] = busy_i[i] && !store_i[i] &&  blocked;
    assign wr_hold_o[i] = busy_i[i] &&  store_i[i] &&  blocked;
  end
endmodule

// File: rtl/ls_conflict_matrix.sv
module ls_conflict_matrix #(
  parameter int N_UNITS = 4,
  parameter int ADDR_W  = 16,
  parameter int TAG_W   = 8,
  localparam int UID_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_valid_i,
  input  logic [UID_W-1:0]   issue_unit_i,
  input  logic               issue_store_i,
  input  logic [ADDR_W-1:0]  issue_addr_i,
  input  logic               done_valid_i,
  input  logic [UID_W-1:0]   done_unit_i,
  output logic [N_UNITS-1:0] rd_ok_o,
  output logic [N_UNITS-1:0] wr_ok_o,
  output logic [N_UNITS-1:0] rd_hold_o,
  output logic [N_UNITS-1:0] wr_hold_o
);
  import ls_cm_pkg::*;

  logic [N_UNITS-1:0]              busy, store, done_oh, live, conflict;
  logic [N_UNITS-1:0][TAG_W-1:0]   tag;
  logic [N_UNITS-1:0][N_UNITS-1:0] blk;
  logic [TAG_W-1:0]                new_tag;
  mem_op_e                         new_op;
  logic                            issue_acc;

  assign new_tag   = issue_addr_i[ADDR_W-1 -: TAG_W];
  assign new_op    = issue_store_i ? OP_STORE : OP_LOAD;
  assign issue_acc = issue_valid_i && !busy[issue_unit_i];
  // a unit completing this cycle is not a blocker for the newcomer
  assign live      = busy & ~done_oh;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_dec
    assign done_oh[i] = done_valid_i && (done_unit_i == UID_W'(i));
  end

  ls_cm_tag_cmp #(.N_UNITS(N_UNITS), .TAG_W(TAG_W)) u_cmp (
    .new_tag_i   (new_tag),
    .new_store_i (new_op == OP_STORE),
    .ent_tag_i   (tag),
    .ent_store_i (store),
    .ent_live_i  (live),
    .conflict_o  (conflict)
  );

  for (genvar i = 0; i < N_UNITS; i++) begin : g_row
    ls_cm_row #(.N_UNITS(N_UNITS), .TAG_W(TAG_W)) u_row (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (issue_acc && (issue_unit_i == UID_W'(i))),
      .free_i      (done_oh[i]),
      .new_store_i (new_op == OP_STORE),
      .new_tag_i   (new_tag),
      .conflict_i  (conflict),
      .clr_i       (done_oh),
      .busy_o      (busy[i]),
      .store_o     (store[i]),
      .tag_o       (tag[i]),
      .blk_o       (blk[i])
    );
  end

  ls_cm_perm #(.N_UNITS(N_UNITS)) u_perm (
    .busy_i    (busy),
    .store_i   (store),
    .blk_i     (blk),
    .rd_ok_o   (rd_ok_o),
    .wr_ok_o   (wr_ok_o),
    .rd_hold_o (rd_hold_o),
    .wr_hold_o (wr_hold_o)
  );
endmodule

// File: rtl/ls_conflict_matrix_chk.sv
module ls_conflict_matrix_chk #(
  parameter int N_UNITS = 4,
  parameter int UID_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               issue_valid_i,
  input logic [UID_W-1:0]   issue_unit_i,
  input logic               done_valid_i,
  input logic [UID_W-1:0]   done_unit_i,
  input logic [N_UNITS-1:0] rd_ok_o,
  input logic [N_UNITS-1:0] wr_ok_o,
  input logic [N_UNITS-1:0] rd_hold_o,
  input logic [N_UNITS-1:0] wr_hold_o
);
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_ok_o == '0 && wr_ok_o == '0 && rd_hold_o == '0 && wr_hold_o == '0));

  for (genvar j = 0; j < N_UNITS; j++) begin : g_chk
    p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rd_ok_o[j], wr_ok_o[j], rd_hold_o[j], wr_hold_o[j]}));

    p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_valid_i && done_unit_i == UID_W'(j)
       && !(issue_valid_i && issue_unit_i == UID_W'(j)))
      |=> !(rd_ok_o[j] || wr_ok_o[j] || rd_hold_o[j] || wr_hold_o[j]));

    p_rd_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok_o[j] && !(done_valid_i && done_unit_i == UID_W'(j))) |=> rd_ok_o[j]);

    p_wr_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok_o[j] && !(done_valid_i && done_unit_i == UID_W'(j))) |=> wr_ok_o[j]);

    p_type_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rd_ok_o[j] || rd_hold_o[j]) && !(done_valid_i && done_unit_i == UID_W'(j)))
      |=> (rd_ok_o[j] || rd_hold_o[j]));
  end
endmodule

bind ls_conflict_matrix ls_conflict_matrix_chk #(.N_UNITS(N_UNITS), .UID_W(UID_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_unit_i  (issue_unit_i),
  .done_valid_i  (done_valid_i),
  .done_unit_i   (done_unit_i),
  .rd_ok_o       (rd_ok_o),
  .wr_ok_o       (wr_ok_o),
  .rd_hold_o     (rd_hold_o),
  .wr_hold_o     (wr_hold_o)
);

// File: tb/ls_conflict_matrix_tb_top.sv
`timescale 1ns/1ps
module ls_conflict_matrix_tb_top;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int UW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid = 1'b0, issue_store = 1'b0, done_valid = 1'b0;
  logic [UW-1:0] issue_unit = '0, done_unit = '0;
  logic [AW-1:0] issue_addr = '0;
  logic [N-1:0]  rd_ok, wr_ok, rd_hold, wr_hold;
  logic [N-1:0]  x_rd_ok, x_wr_ok, x_rd_hold, x_wr_hold;
  int tests = 0, fails = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  ls_conflict_matrix #(.N_UNITS(N), .ADDR_W(AW), .TAG_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .issue_valid_i(issue_valid), .issue_unit_i(issue_unit),
    .issue_store_i(issue_store), .issue_addr_i(issue_addr), .done_valid_i(done_valid),
    .done_unit_i(done_unit), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .rd_hold_o(rd_hold),
    .wr_hold_o(wr_hold));

  ls_conflict_matrix #(.N_UNITS(N), .ADDR_W(AW), .TAG_W(AW)) dut_x_i (
    .clk_i(clk), .rst_ni(rst_ni), .issue_valid_i(issue_valid), .issue_unit_i(issue_unit),
    .issue_store_i(issue_store), .issue_addr_i(issue_addr), .done_valid_i(done_valid),
    .done_unit_i(done_unit), .rd_ok_o(x_rd_ok), .wr_ok_o(x_wr_ok), .rd_hold_o(x_rd_hold),
    .wr_hold_o(x_wr_hold));

  // {rd_ok, wr_ok, rd_hold, wr_hold}
  localparam logic [3:0] S_RD = 4'b1000, S_WR = 4'b0100, H_RD = 4'b0010, H_WR = 4'b0001;

  typedef struct packed {
    logic          a_st;
    logic [AW-1:0] a_addr;
    logic          b_st;
    logic [AW-1:0] b_addr;
    logic [3:0]    exp_b;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h1200, 1'b0, 16'h12FF, H_RD},  // R2, low bits ignored (R6)
    '{1'b0, 16'h1234, 1'b1, 16'h1200, H_WR},  // R3
    '{1'b0, 16'h1200, 1'b0, 16'h1200, S_RD},  // R4
    '{1'b1, 16'h1200, 1'b1, 16'h12AA, H_WR},  // R5
    '{1'b1, 16'h1200, 1'b0, 16'h1300, S_RD},  // R6
    '{1'b0, 16'h1200, 1'b1, 16'h5600, S_WR}   // R6
  };

  function automatic string vec_req(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [3:0] st(int u);
    return {rd_ok[u], wr_ok[u], rd_hold[u], wr_hold[u]};
  endfunction
  function automatic logic [3:0] stx(int u);
    return {x_rd_ok[u], x_wr_ok[u], x_rd_hold[u], x_wr_hold[u]};
  endfunction

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic issue(int u, logic s, logic [AW-1:0] a);
    @(negedge clk);
    issue_valid = 1'b1; issue_unit = UW'(u); issue_store = s; issue_addr = a;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic done(int u);
    @(negedge clk);
    done_valid = 1'b1; done_unit = UW'(u);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: outputs idle during and after reset
    repeat (2) @(negedge clk);
    chk("R1", "in reset", {|rd_ok, |wr_ok, |rd_hold, |wr_hold}, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "after reset", {|rd_ok, |wr_ok, |rd_hold, |wr_hold}, 4'b0000);

    for (int k = 0; k < NV; k++) begin
      issue(0, VEC[k].a_st, VEC[k].a_addr);
      chk("R12", "older unit granted", st(0), VEC[k].a_st ? S_WR : S_RD);
      issue(1, VEC[k].b_st, VEC[k].b_addr);
      chk(vec_req(k), "younger unit", st(1), VEC[k].exp_b);
      chk("R10", "older grant kept", st(0), VEC[k].a_st ? S_WR : S_RD);
      done(0);
      chk("R7", "freed unit idle", st(0), 4'b0000);
      chk("R7", "younger released", st(1), VEC[k].b_st ? S_WR : S_RD);
      done(1);
    end

    // R11: full-width key matches exactly; narrow key is conservative
    issue(0, 1'b1, 16'h1200);
    issue(1, 1'b0, 16'h1201);
    chk("R11", "exact, differ in bit 0", stx(1), S_RD);
    chk("R6", "narrow key, differ in bit 0", st(1), H_RD);
    issue(2, 1'b0, 16'h1200);
    chk("R11", "exact, same address", stx(2), H_RD);
    done(0); done(1); done(2);

    // R8: issue to busy unit ignored
    issue(0, 1'b0, 16'h1200);
    issue(0, 1'b1, 16'h1200);
    chk("R8", "busy unit keeps load", st(0), S_RD);
    issue(1, 1'b1, 16'h1280);
    chk("R8", "kept load still blocks store", st(1), H_WR);
    done(0); done(1);

    // R7: completion and dependent issue in the same cycle
    issue(0, 1'b1, 16'h4400);
    @(negedge clk);
    done_valid = 1'b1; done_unit = 2'd0;
    issue_valid = 1'b1; issue_unit = 2'd1; issue_store = 1'b0; issue_addr = 16'h4400;
    @(negedge clk);
    done_valid = 1'b0; issue_valid = 1'b0;
    chk("R7", "same-cycle newcomer granted", st(1), S_RD);
    chk("R7", "same-cycle freed unit idle", st(0), 4'b0000);
    done(1);

    // R5/R9: chain of three stores, released in order
    issue(0, 1'b1, 16'h7700);
    issue(1, 1'b1, 16'h7711);
    issue(2, 1'b1, 16'h7722);
    chk("R5", "third store waits", st(2), H_WR);
    done(0);
    chk("R5", "third store still waits", st(2), H_WR);
    chk("R9", "second store granted", st(1), S_WR);
    done(1);
    chk("R5", "third store granted", st(2), S_WR);
    done(2);

    // R1: async reset clears busy state
    issue(3, 1'b1, 16'h0100);
    rst_ni = 1'b0;
    #1;
    chk("R1", "async reset clears", st(3), 4'b0000);
    rst_ni = 1'b1;

    summary();
    $finish;
  end
endmodule